// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block holds a small table of VLAN entries inside an Ethernet switch. Each entry is a valid flag, a 12-bit VLAN ID and a port membership mask. Software does not write the table directly. It writes a command word that gives an operation, a VLAN ID and a port number, and sets the start/busy bit. The engine then walks every table slot, one per cycle, applies the operation, posts any result, and clears the busy bit. A second register holds the membership mask and valid flag. It is the operand of a load and the place where lookups by software report their answer.

The engine supports seven operations. These are no-op, flush, load, purge, remove-port, get and get-next. Get-next lets software walk the table in ascending VID order. A separate combinational lookup port lets the forwarding path ask which ports belong to a VID, with no involvement from the command machinery.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset both registers read as zero and the lookup port reports a miss for every VID.
- R2: The command word decodes as follows: operation in bits 2:0 (0 no-op, 1 flush, 2 load, 3 purge, 4 remove-port, 5 get-next, 6 get), busy in bit 3, table-full in bit 4, port in bits 11:8, VID in bits 27:16, priority in bits 30:28 and priority enable in bit 31. Writing it with bit 3 set starts a command. Busy then stays set for at most table depth plus two cycles before it clears.
- R3: While busy is set, writes to either register are ignored.
- R4: A load stores the data register's mask (bits 9:0) for the command VID. If that VID is already in the table, its mask is replaced and no second entry is made.
- R5: A load of a new VID when all 16 slots are in use leaves the table unchanged and sets bit 4. Bit 4 clears when the next command starts.
- R6: A purge removes only the entry whose VID matches.
- R7: A flush removes every entry.
- R8: Remove-port clears the given port's bit in every valid entry. A port number of 10 or more changes nothing.
- R9: A get writes the entry's mask and sets valid (data bit 11) when the VID is present. When the VID is absent, it writes a zero mask with valid clear.
- R10: A get-next finds the entry with the smallest VID strictly greater than the command VID. It writes that VID into command bits 27:16 and its mask with valid set into the data register. When no such entry exists, valid is cleared and the VID is left as it was.
- R11: A no-op completes and changes no table entry.
- R12: The lookup port reports hit and mask for a VID in the same cycle, combinationally from the table. On a miss the mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 command word, 1 data word |
| wr_data | input | 32 | Write value |
| cmd_rdata | output | 32 | Current command word |
| data_rdata | output | 32 | Current data word |
| lookup_vid | input | 12 | VID queried by the forwarding path |
| lookup_hit | output | 1 | Queried VID is present |
| lookup_mask | output | 10 | Member ports of the queried VID |

## Verification
Four properties are checked on every cycle:
- Busy never lasts longer than its bound.
- Neither register moves while a scan is in progress, even when the register is written.
- The full flag only rises at the end of a load.
- Two valid entries never share a VID, and a lookup miss carries a zero mask.

Whether each operation produces the right table contents and results can only be shown by the bench's scenarios, which compare every outcome against a reference model. These scenarios cover overwrite versus new-slot loads, filling all sixteen slots, get-next ordering and its end-of-table case, remove-port with an out-of-range port, and random operation mixes over a narrow VID range.

// File: rtl/vlan_tbl_pkg.sv
package vlan_tbl_pkg;
    localparam int VID_W  = 12;
    localparam int MASK_W = 10;
    localparam int PORT_W = 4;
    localparam int BUSY_BIT  = 3;
    localparam int VALID_BIT = 11;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_FLUSH  = 3'd1,
        OP_LOAD   = 3'd2,
        OP_PURGE  = 3'd3,
        OP_RMPORT = 3'd4,
        OP_NEXT   = 3'd5,
        OP_GET    = 3'd6
    } vlan_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic              valid;
        logic [VID_W-1:0]  vid;
        logic [MASK_W-1:0] mask;
    } vlan_entry_t;

    typedef struct packed {
        logic              prio_en;
        logic [2:0]        prio;
        logic [VID_W-1:0]  vid;
        logic [PORT_W-1:0] port;
        logic              full;
        logic              busy;
        vlan_op_e          op;
    } vlan_cmd_t;

    function automatic logic [31:0] cmd_to_word(vlan_cmd_t c);
        return {c.prio_en, c.prio, c.vid, 4'b0, c.port, 3'b0, c.full, c.busy, c.op};
    endfunction

    function automatic vlan_cmd_t word_to_cmd(logic [31:0] w);
        vlan_cmd_t c;
        c.prio_en = w[31];
        c.prio    = w[30:28];
        c.vid     = w[27:16];
        c.port    = w[11:8];
        c.full    = 1'b0;
        c.busy    = w[BUSY_BIT];
        c.op      = vlan_op_e'(w[2:0]);
        return c;
    endfunction
endpackage

// File: rtl/vlan_entry_store.sv
module vlan_entry_store
    import vlan_tbl_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [IDX_W-1:0]             widx,
    input  vlan_entry_t                  wentry,
    output vlan_entry_t [N_ENTRIES-1:0]  entries
);
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[i] <= '0;
            end else if (we && widx == IDX_W'(i)) begin
                entries[i] <= wentry;
            end
        end
    end
endmodule

// File: rtl/vlan_vid_match.sv
module vlan_vid_match
    import vlan_tbl_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  vlan_entry_t [N_ENTRIES-1:0]  entries,
    input  logic [VID_W-1:0]             vid,
    output logic                         hit,
    output logic [MASK_W-1:0]            mask
);
    logic [N_ENTRIES-1:0] match;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        assign match[i] = entries[i].valid && (entries[i].vid == vid);
    end

    always_comb begin
        mask = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (match[i]) mask = mask | entries[i].mask;
        end
    end

    assign hit = |match;

    // R4: a VID never occupies two valid slots
    assert_unique_vid_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R12: a miss never carries member ports
    assert_miss_zero_mask_R12: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (mask == '0));
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
    import vlan_tbl_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] cmd_rdata,
    output logic [31:0] data_rdata,
    input  logic [11:0] lookup_vid,
    output logic        lookup_hit,
    output logic [9:0]  lookup_mask
);
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam int CNT_W = $clog2(N_ENTRIES + 3);

    eng_state_e                  state_q;
    vlan_cmd_t                   cmd_q;
    logic [MASK_W-1:0]           dmask_q;
    logic                        dvalid_q;
    logic [IDX_W-1:0]            idx_q;
    vlan_entry_t [N_ENTRIES-1:0] table_q;

    logic                        match_found_q, free_found_q, best_found_q;
    logic [IDX_W-1:0]            match_idx_q, free_idx_q;
    logic [MASK_W-1:0]           match_mask_q, best_mask_q;
    logic [VID_W-1:0]            best_vid_q;

    vlan_entry_t                 cur;
    logic                        slot_hit, port_ok, start;
    logic                        st_we;
    logic [IDX_W-1:0]            st_idx;
    vlan_entry_t                 st_entry;

    assign cur      = table_q[idx_q];
    assign slot_hit = cur.valid && (cur.vid == cmd_q.vid);
    assign port_ok  = int'(cmd_q.port) < MASK_W;
    assign start    = (state_q == ST_IDLE) && wr_en && !wr_sel && wr_data[BUSY_BIT];

    // Single table write port: per-slot scan edits, or the load at the end
    always_comb begin
        st_we    = 1'b0;
        st_idx   = idx_q;
        st_entry = cur;
        if (state_q == ST_SCAN) begin
            case (cmd_q.op)
                OP_FLUSH: begin
                    st_we    = 1'b1;
                    st_entry = '0;
                end
                OP_PURGE: begin
                    st_we    = slot_hit;
                    st_entry = '0;
                end
                OP_RMPORT: begin
                    st_we         = cur.valid && port_ok;
                    st_entry.mask = cur.mask & ~(MASK_W'(1) << cmd_q.port);
                end
                default: ;
            endcase
        end else if (state_q == ST_DONE && cmd_q.op == OP_LOAD
                     && (match_found_q || free_found_q)) begin
            st_we    = 1'b1;
            st_idx   = match_found_q ? match_idx_q : free_idx_q;
            st_entry = '{valid: 1'b1, vid: cmd_q.vid, mask: dmask_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            cmd_q         <= '0;
            dmask_q       <= '0;
            dvalid_q      <= 1'b0;
            idx_q         <= '0;
            match_found_q <= 1'b0;
            free_found_q  <= 1'b0;
            best_found_q  <= 1'b0;
            match_idx_q   <= '0;
            free_idx_q    <= '0;
            match_mask_q  <= '0;
            best_mask_q   <= '0;
            best_vid_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (wr_en && !wr_sel) begin
                        vlan_cmd_t nc;
                        nc = word_to_cmd(wr_data);
                        nc.full = start ? 1'b0 : cmd_q.full;
                        cmd_q <= nc;
                        if (start) begin
                            state_q       <= ST_SCAN;
                            idx_q         <= '0;
                            match_found_q <= 1'b0;
                            free_found_q  <= 1'b0;
                            best_found_q  <= 1'b0;
                        end
                    end else if (wr_en && wr_sel) begin
                        dmask_q  <= wr_data[MASK_W-1:0];
                        dvalid_q <= wr_data[VALID_BIT];
                    end
                end
                ST_SCAN: begin
                    if (slot_hit) begin
                        match_found_q <= 1'b1;
                        match_idx_q   <= idx_q;
                        match_mask_q  <= cur.mask;
                    end
                    if (!cur.valid && !free_found_q) begin
                        free_found_q <= 1'b1;
                        free_idx_q   <= idx_q;
                    end
                    if (cur.valid && cur.vid > cmd_q.vid
                        && (!best_found_q || cur.vid < best_vid_q)) begin
                        best_found_q <= 1'b1;
                        best_vid_q   <= cur.vid;
                        best_mask_q  <= cur.mask;
                    end
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(N_ENTRIES - 1)) state_q <= ST_DONE;
                end
                default: begin
                    case (cmd_q.op)
                        OP_LOAD: begin
                            if (!match_found_q && !free_found_q) cmd_q.full <= 1'b1;
                        end
                        OP_GET: begin
                            dvalid_q <= match_found_q;
                            dmask_q  <= match_found_q ? match_mask_q : '0;
                        end
                        OP_NEXT: begin
                            dvalid_q <= best_found_q;
                            dmask_q  <= best_found_q ? best_mask_q : '0;
                            if (best_found_q) cmd_q.vid <= best_vid_q;
                        end
                        default: ;
                    endcase
                    cmd_q.busy <= 1'b0;
                    state_q    <= ST_IDLE;
                end
            endcase
        end
    end

    vlan_entry_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (st_we),
        .widx    (st_idx),
        .wentry  (st_entry),
        .entries (table_q)
    );

    vlan_vid_match #(.N_ENTRIES(N_ENTRIES)) u_lookup (
        .clk     (clk),
        .rst     (rst),
        .entries (table_q),
        .vid     (lookup_vid),
        .hit     (lookup_hit),
        .mask    (lookup_mask)
    );

    assign cmd_rdata  = cmd_to_word(cmd_q);
    assign data_rdata = {20'b0, dvalid_q, 1'b0, dmask_q};

    // Checker state: length of the current busy run
    logic [CNT_W-1:0] busy_run_q;
    always_ff @(posedge clk) begin
        if (rst)             busy_run_q <= '0;
        else if (cmd_q.busy) busy_run_q <= busy_run_q + 1'b1;
        else                 busy_run_q <= '0;
    end

    assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_q.busy |-> (busy_run_q <= CNT_W'(N_ENTRIES)));

    assert_scan_data_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && wr_en) |=> $stable(data_rdata));

    assert_scan_cmd_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && wr_en) |=> $stable(cmd_rdata));

    assert_full_from_load_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_q.full) |-> ($past(cmd_q.op) == OP_LOAD));
endmodule

// File: tb/vlan_cmd_engine_test.sv
module vlan_cmd_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] cmd_rdata, data_rdata;
    logic [11:0] lookup_vid = '0;
    logic        lookup_hit;
    logic [9:0]  lookup_mask;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit         m_valid [N];
    int         m_vid   [N];
    logic [9:0] m_mask  [N];
    int         m_cmd_vid = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlan_cmd_engine #(.N_ENTRIES(N)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
        .lookup_vid(lookup_vid), .lookup_hit(lookup_hit), .lookup_mask(lookup_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd_word(int op, int port, int vid, bit go);
        return {4'b0, 12'(vid), 4'b0, 4'(port), 4'b0, go, 3'(op)};
    endfunction

    function automatic int m_find(int vid);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vid[i] == vid) return i;
        return -1;
    endfunction

    function automatic int m_next(int vid);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vid[i] > vid && (best < 0 || m_vid[i] < m_vid[best])) best = i;
        return best;
    endfunction

    task automatic put(input bit sel, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int cyc = 0;
        while (cmd_rdata[3] && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check(req, (cyc <= N + 2), 1);
    endtask

    // Run a command and update the model; data register must hold mask for loads
    task automatic run(input int op, input int port, input int vid, input logic [9:0] mask);
        bit exp_full = 1'b0;
        if (op == 2) put(1'b1, {20'b0, 1'b1, 1'b0, mask});
        put(1'b0, cmd_word(op, port, vid, 1'b1));
        m_cmd_vid = vid;
        wait_idle("R2 busy bound");
        case (op)
            1: for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
            2: begin
                int k = m_find(vid);
                if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) k = i;
                if (k < 0) exp_full = 1'b1;
                else begin m_valid[k] = 1'b1; m_vid[k] = vid; m_mask[k] = mask; end
            end
            3: begin
                int k = m_find(vid);
                if (k >= 0) m_valid[k] = 1'b0;
            end
            4: if (port < 10) for (int i = 0; i < N; i++) m_mask[i][port] = 1'b0;
            default: ;
        endcase
        check("R5 full flag", cmd_rdata[4], exp_full);
        if (op == 6) begin
            int k = m_find(vid);
            check("R9 get result", data_rdata,
                  (k >= 0) ? {20'b0, 1'b1, 1'b0, m_mask[k]} : 32'h0);
        end
        if (op == 5) begin
            int k = m_next(vid);
            if (k >= 0) m_cmd_vid = m_vid[k];
            check("R10 next data", data_rdata,
                  (k >= 0) ? {20'b0, 1'b1, 1'b0, m_mask[k]} : 32'h0);
            check("R10 next vid", cmd_rdata[27:16], m_cmd_vid);
        end
    endtask

    task automatic probe(input string req, input int vid);
        int k;
        lookup_vid = 12'(vid);
        #1;
        k = m_find(vid);
        check(req, {lookup_hit, lookup_mask}, (k >= 0) ? {1'b1, m_mask[k]} : 11'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_vid[i] = 0; m_mask[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 cmd reset", cmd_rdata, 32'h0);
        check("R1 data reset", data_rdata, 32'h0);
        probe("R1 lookup empty", 0);

        // R4 / R12 load new then overwrite
        run(2, 0, 100, 10'h155);
        probe("R12 lookup after load R4", 100);
        run(2, 0, 100, 10'h0AA);
        probe("R4 overwrite", 100);
        run(6, 0, 100, 0);
        run(6, 0, 101, 0);

        // R3 writes during busy ignored
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = cmd_word(6, 0, 100, 1'b1);
        @(negedge clk);
        wr_sel = 1'b1; wr_data = 32'h0000_0BFF;
        @(negedge clk);
        wr_sel = 1'b0; wr_data = cmd_word(2, 3, 999, 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle("R3 busy bound");
        check("R3 data kept", data_rdata, {20'b0, 1'b1, 1'b0, 10'h0AA});
        check("R3 cmd kept", {cmd_rdata[27:16], cmd_rdata[2:0]}, {12'd100, 3'd6});
        probe("R3 no load of 999", 999);

        // R11 no-op
        run(0, 0, 100, 0);
        probe("R11 table unchanged", 100);

        // R5 fill and overflow
        for (int v = 200; v < 215; v++) run(2, 0, v, 10'(v));
        run(2, 0, 300, 10'h3FF);
        probe("R5 overflow not stored", 300);
        probe("R5 existing kept", 214);
        run(6, 0, 214, 0);

        // R10 get-next ordering and end
        run(5, 0, 150, 0);
        run(5, 0, 214, 0);
        run(5, 0, 0, 0);

        // R8 remove port in range and out of range
        run(4, 1, 0, 0);
        probe("R8 port cleared", 100);
        probe("R8 port cleared 203", 203);
        run(4, 12, 0, 0);
        probe("R8 port 12 no effect", 207);

        // R6 purge one entry
        run(3, 0, 205, 0);
        probe("R6 purged", 205);
        probe("R6 neighbour kept", 206);
        run(2, 0, 300, 10'h3C3);
        probe("R5 load after purge", 300);

        // R7 flush
        run(1, 0, 0, 0);
        for (int v = 200; v < 215; v++) probe("R7 flushed", v);
        run(5, 0, 0, 0);

        // Random mix over a narrow VID range
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom_range(0, 99));
            int vid = int'($urandom_range(0, 23));
            int op;
            if (r < 40) op = 2;
            else if (r < 55) op = 3;
            else if (r < 70) op = 6;
            else if (r < 85) op = 5;
            else if (r < 97) op = 4;
            else op = 1;
            run(op, int'($urandom_range(0, 11)), vid, 10'($urandom));
            probe("R12 random lookup", int'($urandom_range(0, 23)));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule